// File: doc/BRIEF.md
# Cascaded Level Interrupt Aggregator

This block gathers up to sixteen level-sensitive interrupt inputs from board logic and folds them into a single request line for a host processor. Each input has its own capture-enable bit, its own pending bit and its own output-mask bit. A pending bit is sticky. It is set while the source is enabled and its input is high, and it stays set until software acknowledges it. The request line is high whenever any pending bit has its mask bit set.

Software reaches the block over a simple synchronous register bus. Data is 16 bits wide and registers sit on 4-byte boundaries. The enable and mask registers are never written as a whole word. Each has one address where ones set bits and a second address where ones clear bits. Pending bits are acknowledged by writing ones to the status address. A read-only priority word gives the handler the index of the lowest-numbered pending, unmasked source, so it can service that source first.

The request line comes from a two-state machine. REQ_IDLE moves to REQ_ACTIVE (transition *raise*) when any pending bit is also masked in. REQ_ACTIVE returns to REQ_IDLE (transition *drop*) when no such bit is left. Each state holds (*stay_idle*, *stay_active*) otherwise. Read data is registered and appears one cycle after the read strobe.

Top module: `intagg_top`

## Requirements
- R1: After reset, the pending, enable and mask registers read as zero, `irq_out` is low and `bus_rdata` is zero.
- R2: The register word index is `bus_addr[7:2]`, and the byte offsets are: 0x00 pending/acknowledge, 0x04 enable-set, 0x08 enable-clear, 0x0C mask-set, 0x10 mask-clear, 0x14 priority. Both enable addresses read back the enable register, and both mask addresses read back the mask register. Any other offset reads zero. Writes to the priority offset or to any other unused offset change nothing.
- R3: A write to mask-set sets exactly the mask bits where `bus_wdata` holds ones. A write to mask-clear clears exactly those bits. All other mask bits keep their value.
- R4: A write to enable-set sets exactly the enable bits where `bus_wdata` holds ones. A write to enable-clear clears exactly those bits. All other enable bits keep their value.
- R5: At every clock edge where a source's enable bit and its input are both high, its pending bit becomes set. The pending bit stays set after the input falls, until it is acknowledged. A source whose enable bit is low never becomes pending.
- R6: Writing ones to offset 0x00 clears those pending bits at that edge, and the clear wins over a capture at the same edge. If the input is still high and enabled, the bit is set again at the following edge.
- R7: `irq_out` is the registered OR of (pending AND mask). It rises one cycle after the first unmasked pending bit appears and falls one cycle after the last one clears.
- R8: A read of the priority word returns bit 15 = valid and bits 3:0 = index of the lowest set bit of (pending AND mask). The word is 0x0000 when no such bit is set.
- R9: The initialisation sequence works: 0xFFFF to mask-clear, then to enable-set, then to offset 0x00, with all inputs low, leaves every source masked, enabled and not pending.
- R10: `bus_rdata` is loaded at the edge where `bus_rd` is high, with the register value from before that edge's writes. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_lvl | input | 16 | Level-sensitive interrupt inputs |
| irq_out | output | 1 | Combined request to the host |

## Verification
Two functions can fall on the same edge, and this is the collision that matters. One is an acknowledge write to offset 0x00. The other is a capture from a source that is still enabled and high. The bench provokes this directly: it holds an enabled source high while acknowledging its bit, then reads the pending register on the next two cycles. The first read must show the bit cleared and the second must show it set again. Random traffic mixes acknowledges, set/clear writes and toggling inputs in the same cycles. Every cycle is judged against a bench model that applies the clear after the capture.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

    // word indices (byte offset / 4)
    localparam int WIDX_PEND    = 0;
    localparam int WIDX_EN_SET  = 1;
    localparam int WIDX_EN_CLR  = 2;
    localparam int WIDX_MSK_SET = 3;
    localparam int WIDX_MSK_CLR = 4;
    localparam int WIDX_PRIO    = 5;

    typedef enum logic [2:0] {
        RSEL_PEND,
        RSEL_EN,
        RSEL_MSK,
        RSEL_PRIO,
        RSEL_NONE
    } rd_sel_e;

    typedef struct packed {
        logic pend_ack;
        logic en_set;
        logic en_clr;
        logic msk_set;
        logic msk_clr;
    } wr_strb_t;

    typedef enum logic {
        REQ_IDLE,
        REQ_ACTIVE
    } req_state_e;

endpackage

// File: rtl/intagg_decode.sv
module intagg_decode
    import intagg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wr_strb_t          strb,
    output rd_sel_e           rsel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    always_comb begin
        strb = '0;
        rsel = RSEL_NONE;
        unique case (int'(word))
            WIDX_PEND: begin
                strb.pend_ack = wr;
                rsel          = RSEL_PEND;
            end
            WIDX_EN_SET: begin
                strb.en_set = wr;
                rsel        = RSEL_EN;
            end
            WIDX_EN_CLR: begin
                strb.en_clr = wr;
                rsel        = RSEL_EN;
            end
            WIDX_MSK_SET: begin
                strb.msk_set = wr;
                rsel         = RSEL_MSK;
            end
            WIDX_MSK_CLR: begin
                strb.msk_clr = wr;
                rsel         = RSEL_MSK;
            end
            WIDX_PRIO: begin
                rsel = RSEL_PRIO;
            end
            default: begin
                rsel = RSEL_NONE;
            end
        endcase
    end
endmodule

// File: rtl/intagg_setclr.sv
module intagg_setclr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    assign set_v = set_stb ? bits : '0;
    assign clr_v = clr_stb ? bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q | set_v) & ~clr_v;
        end
    end
endmodule

// File: rtl/intagg_pending.sv
module intagg_pending #(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_stb,
    input  logic [NSRC-1:0] ack_bits,
    input  logic [NSRC-1:0] enable,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] pend
);
    // one flop per source, capture then acknowledge (acknowledge wins)
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic hit;
        logic clr;
        assign hit = enable[i] & src[i];
        assign clr = ack_stb & ack_bits[i];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (clr) begin
                pend[i] <= 1'b0;
            end else if (hit) begin
                pend[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/intagg_prio.sv
module intagg_prio #(
    parameter int NSRC  = 16,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  vec,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
        valid = |vec;
    end
endmodule

// File: rtl/intagg_reqfsm.sv
module intagg_reqfsm
    import intagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_live,
    output logic req
);
    req_state_e state;
    req_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= REQ_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            REQ_IDLE:   nxt = any_live ? REQ_ACTIVE : REQ_IDLE;   // raise / stay_idle
            REQ_ACTIVE: nxt = any_live ? REQ_ACTIVE : REQ_IDLE;   // stay_active / drop
            default:    nxt = REQ_IDLE;
        endcase
    end

    always_comb begin
        req = (state == REQ_ACTIVE);
    end
endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int NSRC   = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_lvl,
    output logic              irq_out
);
    localparam int IDX_W = $clog2(NSRC);

    wr_strb_t         strb;
    rd_sel_e          rsel;
    logic [NSRC-1:0]  wbits;
    logic [NSRC-1:0]  enable;
    logic [NSRC-1:0]  mask;
    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  live;
    logic [IDX_W-1:0] prio_idx;
    logic             prio_valid;
    logic [DATA_W-1:0] rd_word;

    assign wbits = bus_wdata[NSRC-1:0];
    assign live  = pend & mask;

    intagg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr   (bus_wr),
        .addr (bus_addr),
        .strb (strb),
        .rsel (rsel)
    );

    intagg_setclr #(.W(NSRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (strb.en_set),
        .clr_stb (strb.en_clr),
        .bits    (wbits),
        .q       (enable)
    );

    intagg_setclr #(.W(NSRC)) u_msk (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (strb.msk_set),
        .clr_stb (strb.msk_clr),
        .bits    (wbits),
        .q       (mask)
    );

    intagg_pending #(.NSRC(NSRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_stb  (strb.pend_ack),
        .ack_bits (wbits),
        .enable   (enable),
        .src      (src_lvl),
        .pend     (pend)
    );

    intagg_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
        .vec   (live),
        .idx   (prio_idx),
        .valid (prio_valid)
    );

    intagg_reqfsm u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_live (|live),
        .req      (irq_out)
    );

    always_comb begin
        rd_word = '0;
        unique case (rsel)
            RSEL_PEND: rd_word[NSRC-1:0] = pend;
            RSEL_EN:   rd_word[NSRC-1:0] = enable;
            RSEL_MSK:  rd_word[NSRC-1:0] = mask;
            RSEL_PRIO: begin
                rd_word[DATA_W-1]  = prio_valid;
                rd_word[IDX_W-1:0] = prio_idx;
            end
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/intagg_chk.sv
module intagg_chk #(
    parameter int NSRC   = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NSRC-1:0]   src_lvl,
    input logic [NSRC-1:0]   enable,
    input logic [NSRC-1:0]   mask,
    input logic [NSRC-1:0]   pend,
    input logic [IDX_W-1:0]  prio_idx,
    input logic              prio_valid,
    input logic              irq_out
);
    logic [ADDR_W-3:0] w;
    logic [NSRC-1:0]   d;
    logic [NSRC-1:0]   lv;
    logic              ack_w;
    assign w     = bus_addr[ADDR_W-1:2];
    assign d     = bus_wdata[NSRC-1:0];
    assign lv    = pend & mask;
    assign ack_w = bus_wr && (w == 0);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pend == '0 && enable == '0 && mask == '0 && !irq_out));

    assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == 3) |=> ((mask & $past(d)) == $past(d)));

    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == 4) |=> ((mask & $past(d)) == '0));

    assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == 1) |=> ((enable & $past(d)) == $past(d)));

    assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == 2) |=> ((enable & $past(d)) == '0));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_w |=> ((pend & $past(enable & src_lvl)) == $past(enable & src_lvl)));

    assert_ack_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_w |=> ((pend & $past(d)) == '0));

    assert_req_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|lv));

    assert_prio_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prio_valid |-> lv[prio_idx]);

    assert_prio_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_valid |-> (lv == '0));
endmodule

bind intagg_top intagg_chk #(
    .NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .src_lvl    (src_lvl),
    .enable     (enable),
    .mask       (mask),
    .pend       (pend),
    .prio_idx   (prio_idx),
    .prio_valid (prio_valid),
    .irq_out    (irq_out)
);

// File: tb/sim_intagg_top.sv
module sim_intagg_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] src_lvl = '0;
    logic        irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model
    logic [15:0] m_pend = '0;
    logic [15:0] m_en   = '0;
    logic [15:0] m_msk  = '0;
    logic [15:0] m_rd   = '0;
    logic        m_irq  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intagg_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_lvl   (src_lvl),
        .irq_out   (irq_out)
    );

    function automatic logic [15:0] lowest_word(input logic [15:0] v);
        for (int i = 0; i < 16; i++) begin
            if (v[i]) return 16'h8000 | 16'(i);
        end
        return 16'h0000;
    endfunction

    function automatic logic [15:0] read_model(input logic [7:0] a);
        case (a[7:2])
            6'd0: return m_pend;
            6'd1, 6'd2: return m_en;
            6'd3, 6'd4: return m_msk;
            6'd5: return lowest_word(m_pend & m_msk);
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle; model updated with pre-edge state, outputs checked after the edge
    task automatic cyc(input string tag, input logic wr, input logic rd,
                       input logic [7:0] a, input logic [15:0] d, input logic [15:0] s);
        logic [15:0] ack;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; src_lvl = s;
        @(posedge clk);
        m_irq = |(m_pend & m_msk);
        if (rd) m_rd = read_model(a);
        ack = (wr && a[7:2] == 6'd0) ? d : 16'h0;
        m_pend = (m_pend | (m_en & s)) & ~ack;
        if (wr && a[7:2] == 6'd1) m_en  = m_en | d;
        if (wr && a[7:2] == 6'd2) m_en  = m_en & ~d;
        if (wr && a[7:2] == 6'd3) m_msk = m_msk | d;
        if (wr && a[7:2] == 6'd4) m_msk = m_msk & ~d;
        #1;
        chk({tag, " R7 irq_out"}, {15'h0, irq_out}, {15'h0, m_irq});
        chk({tag, " R10 rdata"}, bus_rdata, m_rd);
    endtask

    task automatic rd_expect(input string tag, input logic [7:0] a,
                             input logic [15:0] s, input logic [15:0] exp);
        cyc(tag, 1'b0, 1'b1, a, 16'h0, s);
        chk({tag, " direct"}, bus_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  a;
        logic [15:0] d;
        logic [15:0] s;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq after reset", {15'h0, irq_out}, 16'h0);
        chk("R1 rdata after reset", bus_rdata, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        rd_expect("R1 pend", 8'h00, 16'h0, 16'h0000);
        rd_expect("R1 enable", 8'h04, 16'h0, 16'h0000);
        rd_expect("R1 mask", 8'h10, 16'h0, 16'h0000);

        // R4 enable set/clear
        cyc("R4 en set", 1'b1, 1'b0, 8'h04, 16'h00F0, 16'h0);
        rd_expect("R4 en readback", 8'h08, 16'h0, 16'h00F0);
        cyc("R4 en clr", 1'b1, 1'b0, 8'h08, 16'h0030, 16'h0);
        rd_expect("R4 en after clr", 8'h04, 16'h0, 16'h00C0);

        // R3 mask set/clear
        cyc("R3 msk set", 1'b1, 1'b0, 8'h0C, 16'h0F41, 16'h0);
        cyc("R3 msk clr", 1'b1, 1'b0, 8'h10, 16'h0F01, 16'h0);
        rd_expect("R3 mask readback", 8'h0C, 16'h0, 16'h0040);

        // R5 capture: disabled source ignored, enabled one sticky
        cyc("R5 pulse", 1'b0, 1'b0, 8'h00, 16'h0, 16'h0141);
        rd_expect("R5 sticky", 8'h00, 16'h0, 16'h0040);
        #0 chk("R7 irq raised", {15'h0, irq_out}, 16'h0001);

        // R8 priority with two pending unmasked
        cyc("R3 msk set 7", 1'b1, 1'b0, 8'h0C, 16'h0080, 16'h0080);
        rd_expect("R8 prio lowest", 8'h14, 16'h0080, 16'h8006);

        // R6 acknowledge collides with live capture
        cyc("R6 ack", 1'b1, 1'b0, 8'h00, 16'h0080, 16'h0080);
        rd_expect("R6 cleared", 8'h00, 16'h0080, 16'h0040);
        rd_expect("R6 re-pend", 8'h00, 16'h0000, 16'h00C0);

        // R2 ignored writes and unmapped read
        cyc("R2 wr prio", 1'b1, 1'b0, 8'h14, 16'hFFFF, 16'h0);
        cyc("R2 wr unmapped", 1'b1, 1'b0, 8'h1C, 16'hFFFF, 16'h0);
        rd_expect("R2 unmapped rd", 8'h1C, 16'h0, 16'h0000);
        rd_expect("R2 en unchanged", 8'h04, 16'h0, 16'h00C0);
        rd_expect("R2 mask unchanged", 8'h10, 16'h0, 16'h00C0);

        // R10 hold while idle
        cyc("R10 idle", 1'b0, 1'b0, 8'h04, 16'h0, 16'h0);
        chk("R10 hold", bus_rdata, 16'h00C0);

        // R7 drop and R8 empty
        cyc("R6 ack all", 1'b1, 1'b0, 8'h00, 16'hFFFF, 16'h0);
        cyc("R7 drop", 1'b0, 1'b0, 8'h00, 16'h0, 16'h0);
        chk("R7 irq low", {15'h0, irq_out}, 16'h0);
        rd_expect("R8 prio empty", 8'h14, 16'h0, 16'h0000);

        // R9 initialisation sequence
        cyc("R9 mclr", 1'b1, 1'b0, 8'h10, 16'hFFFF, 16'h0);
        cyc("R9 ena", 1'b1, 1'b0, 8'h04, 16'hFFFF, 16'h0);
        cyc("R9 ack", 1'b1, 1'b0, 8'h00, 16'hFFFF, 16'h0);
        rd_expect("R9 mask", 8'h0C, 16'h0, 16'h0000);
        rd_expect("R9 enable", 8'h08, 16'h0, 16'hFFFF);
        rd_expect("R9 pend", 8'h00, 16'h0, 16'h0000);

        // random traffic
        for (int n = 0; n < 600; n++) begin
            a = {3'b0, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
            d = 16'($urandom);
            s = 16'($urandom) & 16'($urandom);
            cyc("RND R5 R6", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d, s);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule